// File: doc/BRIEF.md
# Passive Serial-Debug Transaction Sniffer with Pattern Trigger

This block listens to the two-wire serial debug bus between a debug probe and its target: the clock line and the bidirectional data line. It never drives either wire. Both lines are brought into the system clock domain through synchronizers. Each bit is taken on a detected rising edge of the debug clock. The block rebuilds every transaction from these bits: the 8-bit request, the turnaround gaps, the 3-bit acknowledge, and the 32-bit data word with its parity bit.

When a transaction with an OK acknowledge completes, the block publishes the data word. It then compares the request byte and the data word against preset target values. Each compare has its own per-bit mask, and a bit whose mask is 0 takes no part in the compare. If every enabled bit agrees and the data parity is good, the block raises a one-cycle trigger pulse. That pulse can launch an external fault generator at a precise debug action, such as a single-step or a resume write. With the data mask set to zero, the trigger fires on the request alone.

Top module: `swdSniffer`

## Requirements
- R1: After reset, `hdrOut`, `ackOut`, `dataOut`, `frameValid`, `parityErr` and `matchPulse` are all zero.
- R2: A request is the 8 bits taken after an idle 0 and a start bit of 1, least significant bit first. Bit 0 is start=1, bit 1 selects AP/DP, bit 2 is read-not-write, bits 4:3 are the address, bit 5 is parity, bit 6 is stop=0 and bit 7 is park=1. When the acknowledge completes, the full request byte appears on `hdrOut`.
- R3: A request is dropped if bit 5 differs from the XOR of bits 4:1, if stop is not 0, or if park is not 1. The block then returns to hunting for a start bit, and `hdrOut`, `ackOut` and the pulse outputs do not change.
- R4: One turnaround bit after the request is skipped. The next 3 bits form the acknowledge, least significant bit first, and are shown on `ackOut`. Only the value 3'b001 (OK) leads to a data phase. Any other value ends the transaction after one turnaround bit, with no `frameValid`.
- R5: For a write (bit 2 = 0), one turnaround bit after the acknowledge is skipped. Then 32 data bits (LSB first) and one parity bit follow. `dataOut` takes the word and `frameValid` pulses for one cycle.
- R6: For a read (bit 2 = 1), the data bits follow the acknowledge directly. One turnaround bit follows the parity bit, and the next transaction is then decoded normally.
- R7: The data parity bit must equal the XOR of the 32 data bits. On a mismatch, `parityErr` goes high with `frameValid` and no `matchPulse` is produced. `parityErr` holds until the next completed data phase.
- R8: `matchPulse` pulses for one cycle, together with `frameValid`, when `hdrOut` equals `hdrTarget` on every bit set in `hdrMask`, the data word equals `dataTarget` on every bit set in `dataMask`, and parity is good.
- R9: With `dataMask` all zero, any data word satisfies the data compare, so a header-only match fires.
- R10: A difference in any bit whose mask bit is 1 suppresses `matchPulse`. A difference in a bit whose mask bit is 0 does not.
- R11: Toggling the data line while the debug clock does not rise produces no decode activity and does not disturb the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Active-low synchronous reset |
| swclkIn | input | 1 | Observed debug clock line |
| swdioIn | input | 1 | Observed debug data line |
| hdrTarget | input | 8 | Request byte to match |
| hdrMask | input | 8 | Per-bit enable for the request compare |
| dataTarget | input | 32 | Data word to match |
| dataMask | input | 32 | Per-bit enable for the data compare |
| hdrOut | output | 8 | Last accepted request byte |
| ackOut | output | 3 | Last captured acknowledge |
| dataOut | output | 32 | Last captured data word |
| frameValid | output | 1 | One-cycle pulse when a data phase completes |
| parityErr | output | 1 | Data parity error of the last completed data phase |
| matchPulse | output | 1 | One-cycle trigger on a pattern match |

## Verification
A decoder that loses its bit position shows the error within the same transaction. `dataOut` comes out shifted by one place, the acknowledge reads as a value other than OK, or the expected `frameValid` never arrives. If the decoder confuses reads and writes, a turnaround bit lands inside the data word, and the captured word differs in its top or bottom bit. A decoder stuck outside its idle state fails to decode the transaction that follows. The bench therefore always checks the next transaction after each corner case.

// File: rtl/swdSnifPkg.sv
package swdSnifPkg;
  localparam int HDR_W = 8;
  localparam int ACK_W = 3;
  localparam logic [ACK_W-1:0] ACK_OK = 3'b001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_TRN1, ST_ACK, ST_TRN2, ST_DATA, ST_DPAR, ST_TRN3
  } snifState_t;

  typedef struct packed {
    logic shiftHdr;
    logic shiftAck;
    logic shiftData;
    logic ackDone;
    logic frameDone;
  } dpStrobe_t;
endpackage

// File: rtl/swdSnifSync.sv
module swdSnifSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic swclkIn,
  input  logic swdioIn,
  output logic bitStrobe,
  output logic bitVal
);
  logic [SYNC_STAGES-1:0] clkPipe;
  logic [SYNC_STAGES-1:0] dioPipe;
  logic clkLast;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkPipe <= '0;
          dioPipe <= '0;
        end else begin
          clkPipe <= swclkIn;
          dioPipe <= swdioIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkPipe <= '0;
          dioPipe <= '0;
        end else begin
          clkPipe <= {clkPipe[SYNC_STAGES-2:0], swclkIn};
          dioPipe <= {dioPipe[SYNC_STAGES-2:0], swdioIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) clkLast <= 1'b0;
    else       clkLast <= clkPipe[SYNC_STAGES-1];
  end

  assign bitStrobe = clkPipe[SYNC_STAGES-1] & ~clkLast;
  assign bitVal    = dioPipe[SYNC_STAGES-1];
endmodule

// File: rtl/swdSnifCtrl.sv
module swdSnifCtrl
  import swdSnifPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStrobe,
  input  logic             bitVal,
  input  logic [HDR_W-1:0] hdrQ,
  input  logic [ACK_W-1:0] ackQ,
  output dpStrobe_t        strobes
);
  localparam int CNT_W = (DATA_W > HDR_W) ? $clog2(DATA_W) : $clog2(HDR_W);

  snifState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [HDR_W-1:0] hdrFull;
  logic [ACK_W-1:0] ackFull;
  logic hdrGood;
  logic isRead;

  assign hdrFull = {bitVal, hdrQ[HDR_W-1:1]};
  assign ackFull = {bitVal, ackQ[ACK_W-1:1]};
  assign hdrGood = hdrFull[0] & ~hdrFull[6] & hdrFull[7] & (hdrFull[5] == ^hdrFull[4:1]);
  assign isRead  = hdrQ[2];

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobes   = '0;
    if (bitStrobe) begin
      unique case (state)
        ST_IDLE: if (bitVal) begin
          strobes.shiftHdr = 1'b1;
          stateNext        = ST_HDR;
          cntNext          = CNT_W'(1);
        end
        ST_HDR: begin
          strobes.shiftHdr = 1'b1;
          if (cnt == CNT_W'(HDR_W-1)) begin
            stateNext = hdrGood ? ST_TRN1 : ST_IDLE;
            cntNext   = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_TRN1: begin
          stateNext = ST_ACK;
          cntNext   = '0;
        end
        ST_ACK: begin
          strobes.shiftAck = 1'b1;
          if (cnt == CNT_W'(ACK_W-1)) begin
            strobes.ackDone = 1'b1;
            cntNext         = '0;
            if (ackFull == ACK_OK) stateNext = isRead ? ST_DATA : ST_TRN2;
            else                   stateNext = ST_TRN3;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_TRN2: begin
          stateNext = ST_DATA;
          cntNext   = '0;
        end
        ST_DATA: begin
          strobes.shiftData = 1'b1;
          if (cnt == CNT_W'(DATA_W-1)) begin
            stateNext = ST_DPAR;
            cntNext   = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_DPAR: begin
          strobes.frameDone = 1'b1;
          stateNext         = isRead ? ST_TRN3 : ST_IDLE;
        end
        ST_TRN3: stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end
endmodule

// File: rtl/swdSnifDatapath.sv
module swdSnifDatapath
  import swdSnifPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitVal,
  input  dpStrobe_t         strobes,
  input  logic [HDR_W-1:0]  hdrTarget,
  input  logic [HDR_W-1:0]  hdrMask,
  input  logic [DATA_W-1:0] dataTarget,
  input  logic [DATA_W-1:0] dataMask,
  output logic [HDR_W-1:0]  hdrQ,
  output logic [ACK_W-1:0]  ackQ,
  output logic [HDR_W-1:0]  hdrOut,
  output logic [ACK_W-1:0]  ackOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              frameValid,
  output logic              parityErr,
  output logic              matchPulse
);
  logic [DATA_W-1:0] dataQ;
  logic parOk, hdrHit, dataHit;

  assign parOk   = (^dataQ) == bitVal;
  assign hdrHit  = ((hdrQ ^ hdrTarget) & hdrMask) == '0;
  assign dataHit = ((dataQ ^ dataTarget) & dataMask) == '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrQ  <= '0;
      ackQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strobes.shiftHdr)  hdrQ  <= {bitVal, hdrQ[HDR_W-1:1]};
      if (strobes.shiftAck)  ackQ  <= {bitVal, ackQ[ACK_W-1:1]};
      if (strobes.shiftData) dataQ <= {bitVal, dataQ[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrOut     <= '0;
      ackOut     <= '0;
      dataOut    <= '0;
      frameValid <= 1'b0;
      parityErr  <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      frameValid <= strobes.frameDone;
      matchPulse <= strobes.frameDone & parOk & hdrHit & dataHit;
      if (strobes.ackDone) begin
        hdrOut <= hdrQ;
        ackOut <= {bitVal, ackQ[ACK_W-1:1]};
      end
      if (strobes.frameDone) begin
        dataOut   <= dataQ;
        parityErr <= ~parOk;
      end
    end
  end
endmodule

// File: rtl/swdSniffer.sv
module swdSniffer #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swclkIn,
  input  logic              swdioIn,
  input  logic [7:0]        hdrTarget,
  input  logic [7:0]        hdrMask,
  input  logic [DATA_W-1:0] dataTarget,
  input  logic [DATA_W-1:0] dataMask,
  output logic [7:0]        hdrOut,
  output logic [2:0]        ackOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              frameValid,
  output logic              parityErr,
  output logic              matchPulse
);
  import swdSnifPkg::*;

  logic bitStrobe, bitVal;
  logic [HDR_W-1:0] hdrQ;
  logic [ACK_W-1:0] ackQ;
  dpStrobe_t strobes;

  swdSnifSync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .swclkIn(swclkIn), .swdioIn(swdioIn),
    .bitStrobe(bitStrobe), .bitVal(bitVal)
  );

  swdSnifCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .bitVal(bitVal),
    .hdrQ(hdrQ), .ackQ(ackQ), .strobes(strobes)
  );

  swdSnifDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .bitVal(bitVal), .strobes(strobes),
    .hdrTarget(hdrTarget), .hdrMask(hdrMask),
    .dataTarget(dataTarget), .dataMask(dataMask),
    .hdrQ(hdrQ), .ackQ(ackQ), .hdrOut(hdrOut), .ackOut(ackOut),
    .dataOut(dataOut), .frameValid(frameValid), .parityErr(parityErr),
    .matchPulse(matchPulse)
  );
endmodule

// File: rtl/swdSnifChecker.sv
module swdSnifChecker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] hdrOut,
  input logic [2:0] ackOut,
  input logic       frameValid,
  input logic       parityErr,
  input logic       matchPulse
);
  p_match_with_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> frameValid);

  p_match_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse);

  p_no_match_on_bad_par_r7: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> !parityErr);

  p_frame_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  p_frame_needs_ok_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> ackOut == 3'b001);

  p_frame_hdr_framing_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> (hdrOut[0] && !hdrOut[6] && hdrOut[7]));

  p_frame_hdr_parity_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> (hdrOut[5] == ^hdrOut[4:1]));
endmodule

bind swdSniffer swdSnifChecker u_chk (
  .clk(clk), .rstN(rstN), .hdrOut(hdrOut), .ackOut(ackOut),
  .frameValid(frameValid), .parityErr(parityErr), .matchPulse(matchPulse)
);

// File: tb/test_swdSniffer.sv
module test_swdSniffer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swclkIn = 1'b0;
  logic swdioIn = 1'b0;
  logic [7:0]  hdrTarget = '0;
  logic [7:0]  hdrMask = '0;
  logic [31:0] dataTarget = '0;
  logic [31:0] dataMask = '0;
  logic [7:0]  hdrOut;
  logic [2:0]  ackOut;
  logic [31:0] dataOut;
  logic frameValid, parityErr, matchPulse;

  int checks = 0;
  int errors = 0;
  int frameCnt = 0;
  int matchCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  swdSniffer i_swdSniffer (
    .clk(clk), .rstN(rstN), .swclkIn(swclkIn), .swdioIn(swdioIn),
    .hdrTarget(hdrTarget), .hdrMask(hdrMask),
    .dataTarget(dataTarget), .dataMask(dataMask),
    .hdrOut(hdrOut), .ackOut(ackOut), .dataOut(dataOut),
    .frameValid(frameValid), .parityErr(parityErr), .matchPulse(matchPulse)
  );

  always @(posedge clk) begin
    if (rstN && frameValid) frameCnt <= frameCnt + 1;
    if (rstN && matchPulse) matchCnt <= matchCnt + 1;
  end

  typedef struct packed {
    logic        ap;
    logic        rnw;
    logic [1:0]  addr;
    logic [31:0] data;
    logic        badPar;
    logic        expMatch;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 2'b01, 32'hABCD_1234, 1'b0, 1'b1},
    '{1'b1, 1'b0, 2'b01, 32'hABCE_1234, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b01, 32'hABCD_5678, 1'b1, 1'b0},
    '{1'b1, 1'b1, 2'b01, 32'hABCD_0000, 1'b0, 1'b0},
    '{1'b0, 1'b0, 2'b01, 32'hABCD_9999, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b01, 32'hABCD_FFFF, 1'b0, 1'b1}
  };

  function automatic logic [7:0] mkHdr(input logic ap, input logic rnw, input logic [1:0] a);
    return {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); swdioIn = b;
    repeat (3) @(negedge clk);
    swclkIn = 1'b1;
    repeat (4) @(negedge clk);
    swclkIn = 1'b0;
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  task automatic doTxn(input logic [7:0] hdr, input logic [2:0] ack,
                       input logic [31:0] data, input logic flipPar);
    for (int i = 0; i < 8; i++) sendBit(hdr[i]);
    sendBit(1'b1);
    for (int i = 0; i < 3; i++) sendBit(ack[i]);
    if (ack == 3'b001) begin
      if (!hdr[2]) sendBit(1'b1);
      for (int i = 0; i < 32; i++) sendBit(data[i]);
      sendBit((^data) ^ flipPar);
      if (hdr[2]) sendBit(1'b1);
    end else begin
      sendBit(1'b1);
    end
    idleBits(3);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int fBefore, mBefore;
    logic [7:0] hdrPrev;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 hdrOut", hdrOut, 0);
    check("R1 ackOut", ackOut, 0);
    check("R1 dataOut", dataOut, 0);
    check("R1 frameValid", frameValid, 0);
    check("R1 parityErr", parityErr, 0);
    check("R1 matchPulse", matchPulse, 0);

    hdrTarget  = mkHdr(1'b1, 1'b0, 2'b01);
    hdrMask    = 8'hFF;
    dataTarget = 32'hABCD_0000;
    dataMask   = 32'hFFFF_0000;
    idleBits(2);

    // Table walk: R2 R5 R6 R7 R8 R10
    for (int v = 0; v < 6; v++) begin
      logic [7:0] h;
      h = mkHdr(VECS[v].ap, VECS[v].rnw, VECS[v].addr);
      fBefore = frameCnt; mBefore = matchCnt;
      doTxn(h, 3'b001, VECS[v].data, VECS[v].badPar);
      check("R2 hdrOut", hdrOut, h);
      check("R4 ackOut ok", ackOut, 3'b001);
      check(VECS[v].rnw ? "R6 read dataOut" : "R5 write dataOut", dataOut, VECS[v].data);
      check("R5 frameValid count", frameCnt - fBefore, 1);
      check("R7 parityErr", parityErr, VECS[v].badPar);
      check("R8 R10 match count", matchCnt - mBefore, VECS[v].expMatch);
    end

    // R3: bad parity, bad stop, bad park are each dropped
    hdrPrev = hdrOut;
    fBefore = frameCnt;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] bad;
      bad = mkHdr(1'b1, 1'b0, 2'b10);
      if (k == 0) bad[5] = ~bad[5];
      if (k == 1) bad[6] = 1'b1;
      if (k == 2) bad[7] = 1'b0;
      for (int i = 0; i < 8; i++) sendBit(bad[i]);
      idleBits(4);
      repeat (8) @(negedge clk);
      check("R3 hdrOut unchanged", hdrOut, hdrPrev);
    end
    check("R3 no frame", frameCnt - fBefore, 0);
    check("R3 ackOut unchanged", ackOut, 3'b001);

    // R4: WAIT acknowledge, no data phase; next txn decoded
    fBefore = frameCnt;
    doTxn(mkHdr(1'b0, 1'b1, 2'b11), 3'b010, 32'h0, 1'b0);
    check("R4 ackOut wait", ackOut, 3'b010);
    check("R4 hdrOut on wait", hdrOut, mkHdr(1'b0, 1'b1, 2'b11));
    check("R4 no frame on wait", frameCnt - fBefore, 0);
    doTxn(mkHdr(1'b1, 1'b0, 2'b01), 3'b001, 32'h1357_9BDF, 1'b0);
    check("R4 recover data", dataOut, 32'h1357_9BDF);

    // R6: read then write back to back
    doTxn(mkHdr(1'b0, 1'b1, 2'b00), 3'b001, 32'h8000_0001, 1'b0);
    check("R6 read data", dataOut, 32'h8000_0001);
    doTxn(mkHdr(1'b1, 1'b0, 2'b11), 3'b001, 32'h0F0F_F0F0, 1'b0);
    check("R6 following write data", dataOut, 32'h0F0F_F0F0);

    // R9: header-only match on a read
    hdrTarget = mkHdr(1'b0, 1'b1, 2'b11);
    dataMask  = 32'h0;
    mBefore = matchCnt;
    doTxn(mkHdr(1'b0, 1'b1, 2'b11), 3'b001, 32'hDEAD_BEEF, 1'b0);
    check("R9 header-only match", matchCnt - mBefore, 1);
    // R10: masked header bit ignored, unmasked bit blocks
    hdrMask = 8'hE7;
    mBefore = matchCnt;
    doTxn(mkHdr(1'b0, 1'b1, 2'b00), 3'b001, 32'h1, 1'b0);
    check("R10 masked addr ignored", matchCnt - mBefore, 1);
    mBefore = matchCnt;
    doTxn(mkHdr(1'b1, 1'b1, 2'b11), 3'b001, 32'h1, 1'b0);
    check("R10 unmasked ap blocks", matchCnt - mBefore, 0);

    // R11: data line noise without clock edges
    fBefore = frameCnt;
    hdrPrev = hdrOut;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); swdioIn = ~swdioIn;
    end
    @(negedge clk); swdioIn = 1'b0;
    repeat (8) @(negedge clk);
    check("R11 no frame on noise", frameCnt - fBefore, 0);
    check("R11 hdrOut unchanged", hdrOut, hdrPrev);
    doTxn(mkHdr(1'b1, 1'b0, 2'b10), 3'b001, 32'h2468_ACE0, 1'b0);
    check("R11 next txn data", dataOut, 32'h2468_ACE0);
    check("R11 next txn hdr", hdrOut, mkHdr(1'b1, 1'b0, 2'b10));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule